// File: doc/BRIEF.md
# I2C Command-Sequenced Bus Master

This block is a single-master I2C controller. Software runs the bus one byte-level cycle at a time. It first loads the slave address with its direction flag, and for a write it also loads the byte to send. It then writes a four-bit command word to the control register. The same register address returns controller status when read. Each command can open the cycle with a START, or with a repeated START when this master still holds the bus. It then moves the address byte and one data byte, and it can either close with a STOP or keep the bus for the next command. Software can therefore chain write-then-read transactions and multi-byte transfers without releasing the bus.

The bus pins are open-drain. The block pulls SCL or SDA low by raising the matching output-enable, and it reads the real line levels back. A programmable divider sets the SCL low and high phase lengths. A high phase only starts counting once the SCL line is seen high, so a slave that holds SCL low simply delays the cycle. When a cycle ends, whether it completes or stops on a NACK, a sticky interrupt flag is set. Software clears that flag by writing a one to it.

Register word indices on `bus_addr`: 0 = slave address, 1 = command (write) / status (read), 2 = data, 3 = divider, 4 = interrupt enable, 5 = interrupt flag.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the status reads 0, the interrupt flag and `irq` are 0, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: Command word fields are bit 0 RUN, bit 1 START, bit 2 STOP, bit 3 ACK. A command with RUN=0 starts no bus activity. A command with START=0 while the bus is not held starts no bus activity either.
- R3: START=1 on a free bus produces a START condition, which is SDA falling while SCL is high. It then sends the address byte MSB first. The slave-address register holds the 7-bit address in bits 7:1 and the direction in bit 0 (1 = read), and this byte is sent unchanged.
- R4: With STOP=1 the cycle ends with a STOP condition and frees the bus. With STOP=0 the block keeps SCL pulled low and status bit 4 (BUS_BUSY) stays 1.
- R5: START=1 while the bus is held produces a repeated START with no STOP in between.
- R6: In write direction the data register byte is sent after an acknowledged address. A slave NACK on that byte sets status bit 3 (DATA_NACK) and bit 1 (ERROR).
- R7: A NACK on the address byte sets status bit 2 (ADDR_NACK) and bit 1 (ERROR). No data byte is moved, and a STOP is still issued when STOP=1.
- R8: In read direction the received byte appears in the data register. In the acknowledge slot the master pulls SDA low when ACK=1 and leaves it released when ACK=0.
- R9: RUN=1 with START=0 on a held bus moves one data byte with no address byte.
- R10: A command written while status bit 0 (BUSY) is 1 is ignored.
- R11: Each finished cycle sets the interrupt flag (index 5, bit 0). The flag stays set until a 1 is written to that bit. `irq` equals the flag gated by the enable (index 4, bit 0).
- R12: An SCL high phase lasts exactly the divider value in clock cycles, counted from the moment the SCL line is high. A slave holding SCL low delays the phase and does not shorten it.
- R13: SDA changes only while SCL is low, except for START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| irq | output | 1 | Interrupt, flag AND enable |

## Verification
The hardest situations to reach from the ports are a slave holding SCL low in the middle of a bit, and a command that arrives while a cycle is already in flight. The bench's slave model stretches SCL low across the start of a high phase and then measures the high time after release. It also issues a second command a few cycles after the first one and counts START conditions on the wire. Chained sequences are driven in a fixed order: hold, data-only, repeated-START read, then acknowledged read followed by NACKed read. These are mixed with seeded random transfers that vary address match, direction, data and slave NACK.

// File: rtl/i2c_cmd_pkg.sv
// Shared types for the command-sequenced I2C master.
// Assumes: a single bus master; register word indices are fixed here.
package i2c_cmd_pkg;

    // Register word indices
    localparam logic [2:0] REG_SLAVE = 3'd0;
    localparam logic [2:0] REG_CTRL  = 3'd1;
    localparam logic [2:0] REG_DATA  = 3'd2;
    localparam logic [2:0] REG_DIV   = 3'd3;
    localparam logic [2:0] REG_IEN   = 3'd4;
    localparam logic [2:0] REG_IFLAG = 3'd5;

    // Command word, bit 3 down to bit 0
    typedef struct packed {
        logic ack;
        logic stop;
        logic start;
        logic run;
    } cmd_t;

    // Status word, bit 4 down to bit 0
    typedef struct packed {
        logic bus_busy;
        logic data_nack;
        logic addr_nack;
        logic error;
        logic busy;
    } status_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RS_LOW,
        ST_RS_HIGH,
        ST_START,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_TAIL,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_STOP_END
    } bus_state_t;

endpackage

// File: rtl/i2c_phase_timer.sv
// Half-bit phase timer: pulses tick after DIV_W-wide 'div' running cycles.
// Assumes: the counter restarts whenever run drops; div of 0 acts as 1.
module i2c_phase_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    // Effective divider, never zero
    always_comb div_eff = (div == '0) ? ONE : div;

    // Tick on the last cycle of a phase
    always_comb tick = run && (cnt >= div_eff - ONE);

    // Phase counter, cleared when idle, stalled or at a phase end
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                 cnt <= cnt + ONE;
    end

    // R12: after a phase end the next phase starts counting from zero
    p_phase_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

endmodule

// File: rtl/i2c_cmd_regs.sv
// Register file: slave address, command/status, data, divider, interrupt.
// Assumes: reads are combinational, writes take effect on the next edge;
// the command is forwarded as a one-cycle pulse.
module i2c_cmd_regs
    import i2c_cmd_pkg::*;
#(
    parameter int               DIV_W    = 16,
    parameter logic [DIV_W-1:0] DIV_INIT = DIV_W'(4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  status_t          stat,
    input  logic [7:0]       rx_byte,
    input  logic             done,
    output logic             cmd_valid,
    output cmd_t             cmd,
    output logic [7:0]       slave_byte,
    output logic [7:0]       tx_byte,
    output logic [DIV_W-1:0] div,
    output logic             irq
);
    localparam int SPARE_W = 32 - DIV_W;

    logic ien;
    logic irq_flag;
    logic wr;
    logic unused_wdata;

    assign wr           = sel && we;
    assign unused_wdata = ^wdata;

    // Configuration registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_byte <= '0;
            tx_byte    <= '0;
            div        <= DIV_INIT;
            ien        <= 1'b0;
        end else if (wr) begin
            case (addr)
                REG_SLAVE: slave_byte <= wdata[7:0];
                REG_DATA:  tx_byte    <= wdata[7:0];
                REG_DIV:   div        <= wdata[DIV_W-1:0];
                REG_IEN:   ien        <= wdata[0];
                default: ;
            endcase
        end
    end

    // One-cycle command pulse toward the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= wr && (addr == REG_CTRL);
            if (wr && (addr == REG_CTRL)) cmd <= cmd_t'(wdata[3:0]);
        end
    end

    // Sticky interrupt flag: set on done, write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                                        irq_flag <= 1'b0;
        else if (done)                                     irq_flag <= 1'b1;
        else if (wr && (addr == REG_IFLAG) && wdata[0])    irq_flag <= 1'b0;
    end

    assign irq = irq_flag && ien;

    // Read multiplexer
    always_comb begin
        case (addr)
            REG_SLAVE: rdata = {24'd0, slave_byte};
            REG_CTRL:  rdata = {27'd0, stat};
            REG_DATA:  rdata = {24'd0, rx_byte};
            REG_DIV:   rdata = {{SPARE_W{1'b0}}, div};
            REG_IEN:   rdata = {31'd0, ien};
            REG_IFLAG: rdata = {31'd0, irq_flag};
            default:   rdata = '0;
        endcase
    end

    // R11: a finished cycle always leaves the flag set
    p_done_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_flag);

endmodule

// File: rtl/i2c_bus_seq.sv
// Bus sequencer: turns one accepted command into START/repeated START,
// address byte, data byte, acknowledge handling and optional STOP.
// Assumes: single master; each state lasts one timer phase; the timer
// stalls while SCL is released but still held low by another device.
module i2c_bus_seq
    import i2c_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  cmd_t       cmd,
    input  logic [7:0] slave_byte,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       tmr_run,
    output status_t    stat,
    output logic [7:0] rx_byte,
    output logic       done
);
    bus_state_t state;
    logic       held;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       is_addr;
    logic       rd_mode;
    logic       cur_ack;
    logic       cur_stop;
    logic       addr_nack;
    logic       data_nack;
    logic       accept;
    logic       bit_drv;
    logic       ack_slot;

    assign ack_slot = (bit_cnt == 4'd8);
    assign accept   = cmd_valid && cmd.run && (cmd.start || held);

    // SDA pull for the current bit: data bits when sending, ACK when reading
    always_comb begin
        if (!ack_slot) bit_drv = (is_addr || !rd_mode) ? ~shreg[7] : 1'b0;
        else           bit_drv = (!is_addr && rd_mode) ? cur_ack : 1'b0;
    end

    // Line drivers decoded from the bus state
    always_comb begin
        case (state)
            ST_IDLE:                               scl_oe = held;
            ST_RS_LOW, ST_BIT_LOW, ST_TAIL,
            ST_STOP_LOW:                           scl_oe = 1'b1;
            default:                               scl_oe = 1'b0;
        endcase
        case (state)
            ST_START, ST_STOP_LOW, ST_STOP_HIGH:   sda_oe = 1'b1;
            ST_BIT_LOW, ST_BIT_HIGH, ST_TAIL:      sda_oe = bit_drv;
            default:                               sda_oe = 1'b0;
        endcase
    end

    // Timer runs in any active phase unless SCL is released but still low
    assign tmr_run = (state != ST_IDLE) && !(!scl_oe && !scl_in);

    // Status word
    always_comb begin
        stat.busy      = (state != ST_IDLE);
        stat.error     = addr_nack || data_nack;
        stat.addr_nack = addr_nack;
        stat.data_nack = data_nack;
        stat.bus_busy  = held || (state != ST_IDLE);
    end

    // Bus cycle state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            held      <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            is_addr   <= 1'b0;
            rd_mode   <= 1'b0;
            cur_ack   <= 1'b0;
            cur_stop  <= 1'b0;
            addr_nack <= 1'b0;
            data_nack <= 1'b0;
            rx_byte   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_ack   <= cmd.ack;
                        cur_stop  <= cmd.stop;
                        addr_nack <= 1'b0;
                        data_nack <= 1'b0;
                        bit_cnt   <= '0;
                        if (cmd.start) begin
                            shreg   <= slave_byte;
                            is_addr <= 1'b1;
                            rd_mode <= slave_byte[0];
                            state   <= held ? ST_RS_LOW : ST_START;
                        end else begin
                            shreg   <= tx_byte;
                            is_addr <= 1'b0;
                            state   <= ST_BIT_LOW;
                        end
                    end
                end
                ST_RS_LOW:  if (tick) state <= ST_RS_HIGH;
                ST_RS_HIGH: if (tick) state <= ST_START;
                ST_START:   if (tick) state <= ST_BIT_LOW;
                ST_BIT_LOW: if (tick) state <= ST_BIT_HIGH;
                ST_BIT_HIGH: begin
                    if (tick) begin
                        if (!ack_slot) begin
                            shreg   <= {shreg[6:0], sda_in};
                            bit_cnt <= bit_cnt + 4'd1;
                            state   <= ST_BIT_LOW;
                        end else if (is_addr) begin
                            if (sda_in) begin
                                addr_nack <= 1'b1;
                                state     <= ST_TAIL;
                            end else begin
                                shreg   <= tx_byte;
                                is_addr <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_BIT_LOW;
                            end
                        end else begin
                            if (rd_mode)     rx_byte   <= shreg;
                            else if (sda_in) data_nack <= 1'b1;
                            state <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        if (cur_stop) begin
                            state <= ST_STOP_LOW;
                        end else begin
                            held  <= 1'b1;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_STOP_LOW:  if (tick) state <= ST_STOP_HIGH;
                ST_STOP_HIGH: if (tick) state <= ST_STOP_END;
                ST_STOP_END: begin
                    if (tick) begin
                        held  <= 1'b0;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a command without RUN leaves the sequencer idle
    p_norun_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid && !cmd.run) |=> (state == ST_IDLE));

    // R3: bit counter never passes the acknowledge slot
    p_bitcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    // R4: finishing a STOP releases the bus
    p_stop_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP_END && tick) |=> (!held && state == ST_IDLE));

    // R10: a command arriving mid-cycle changes no latched command bit
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cmd_valid) |=>
            ($stable(cur_stop) && $stable(cur_ack) && $stable(rd_mode)));

    // R13: SDA held steady through an SCL high data phase
    p_sda_steady_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HIGH && !tick) |=> $stable(sda_oe));

endmodule

// File: rtl/i2c_cmd_master.sv
// Top: command-sequenced single-master I2C controller.
// Assumes: open-drain pads outside the block; scl_in/sda_in already
// synchronised to clk.
module i2c_cmd_master #(
    parameter int               DIV_W    = 16,
    parameter logic [DIV_W-1:0] DIV_INIT = DIV_W'(4)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        irq
);
    import i2c_cmd_pkg::*;

    logic             cmd_valid;
    cmd_t             cmd;
    logic [7:0]       slave_byte;
    logic [7:0]       tx_byte;
    logic [DIV_W-1:0] div;
    status_t          stat;
    logic [7:0]       rx_byte;
    logic             done;
    logic             tmr_run;
    logic             tick;

    i2c_cmd_regs #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .stat(stat), .rx_byte(rx_byte), .done(done),
        .cmd_valid(cmd_valid), .cmd(cmd), .slave_byte(slave_byte),
        .tx_byte(tx_byte), .div(div), .irq(irq)
    );

    i2c_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .div(div), .tick(tick)
    );

    i2c_bus_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .slave_byte(slave_byte), .tx_byte(tx_byte), .tick(tick),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .tmr_run(tmr_run), .stat(stat), .rx_byte(rx_byte), .done(done)
    );

endmodule

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
    localparam logic [6:0] SLV = 7'h2A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        scl_oe, sda_oe, irq;
    logic        scl_line, sda_line;

    // Slave model state
    logic        stretch = 1'b0;
    logic        slv_pull = 1'b0;
    logic        nack_data = 1'b0;
    logic [7:0]  rd_byte = 8'h00;
    logic [7:0]  got_byte = 8'h00;
    logic [7:0]  addr_seen = 8'h00;
    logic [7:0]  shift = 8'h00;
    logic        mack = 1'b0;
    logic        scl_prev = 1'b1, sda_prev = 1'b1;
    logic        in_xfer = 1'b0, first = 1'b0, rose = 1'b0, sel = 1'b0, rd = 1'b0;
    int          bitn = 0;
    int          starts = 0, stops = 0, got_cnt = 0;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    assign scl_line = !(scl_oe || stretch);
    assign sda_line = !(sda_oe || slv_pull);

    always #5 clk = ~clk;

    i2c_cmd_master i_i2c_cmd_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_line), .sda_in(sda_line),
        .irq(irq)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    // Behavioural slave at address SLV, sampled away from the DUT edge
    always @(negedge clk) begin
        if (!rst_n) begin
            in_xfer = 0; slv_pull = 0; bitn = 0; rose = 0;
        end else begin
            if (scl_prev && scl_line && sda_prev && !sda_line) begin
                starts++; in_xfer = 1; bitn = 0; first = 1; rose = 0; slv_pull = 0;
            end else if (scl_prev && scl_line && !sda_prev && sda_line) begin
                stops++; in_xfer = 0; slv_pull = 0;
            end else if (in_xfer && !scl_prev && scl_line) begin
                rose = 1;
                if (bitn < 8) shift = {shift[6:0], sda_line};
                else          mack = !sda_line;
            end else if (in_xfer && scl_prev && !scl_line && rose) begin
                rose = 0;
                bitn++;
                if (bitn == 8) begin
                    if (first) begin
                        addr_seen = shift;
                        sel = (shift[7:1] == SLV); rd = shift[0]; slv_pull = sel;
                    end else if (sel && !rd) begin
                        got_byte = shift; got_cnt++; slv_pull = !nack_data;
                    end else slv_pull = 0;
                end else if (bitn == 9) begin
                    bitn = 0;
                    if (sel && rd && (first || mack)) slv_pull = !rd_byte[7];
                    else begin
                        slv_pull = 0;
                        if (!first && rd) sel = 0;
                    end
                    first = 0;
                end else if (sel && rd && !first) begin
                    slv_pull = !rd_byte[7-bitn];
                end
            end
            scl_prev = scl_line; sda_prev = sda_line;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    // Wait for the interrupt pin, then clear the flag
    task automatic wait_done(input string tag);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        if (!irq) chk({tag, " done timeout"}, 32'd0, 32'd1);
        reg_wr(3'd5, 32'd1);
    endtask

    function automatic logic [31:0] exp_status(input logic match, input logic rdir,
                                               input logic nk, input logic hold);
        logic dn = match && !rdir && nk;
        return {27'd0, hold, dn, !match, dn || !match, 1'b0};
    endfunction

    initial begin
        logic [31:0] d;
        int n, s0, p0, g0;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        reg_rd(3'd1, d); chk("R1 status", d, 0);
        reg_rd(3'd5, d); chk("R1 flag", d, 0);
        chk("R1 pins", {29'd0, irq, scl_oe, sda_oe}, 0);

        reg_wr(3'd3, 32'd4);
        reg_wr(3'd4, 32'd1);

        // R2 RUN=0, and RUN without START on a free bus
        s0 = starts;
        reg_wr(3'd1, 32'h6);
        repeat (60) @(negedge clk);
        reg_wr(3'd1, 32'h1);
        repeat (60) @(negedge clk);
        chk("R2 no start", starts - s0, 0);
        reg_rd(3'd1, d); chk("R2 status", d, 0);
        reg_rd(3'd5, d); chk("R2 no flag", d, 0);

        // R3 / R6 write with STOP
        s0 = starts; p0 = stops;
        reg_wr(3'd0, {SLV, 1'b0}); reg_wr(3'd2, 32'hA5); reg_wr(3'd1, 32'h7);
        wait_done("R3");
        chk("R3 addr byte", addr_seen, {SLV, 1'b0});
        chk("R6 data byte", got_byte, 8'hA5);
        chk("R3 one start", starts - s0, 1);
        chk("R4 one stop", stops - p0, 1);
        reg_rd(3'd1, d); chk("R6 status", d, 0);

        // R7 address NACK, STOP still issued
        g0 = got_cnt; p0 = stops;
        reg_wr(3'd0, {SLV ^ 7'h11, 1'b0}); reg_wr(3'd1, 32'h7);
        wait_done("R7");
        reg_rd(3'd1, d); chk("R7 status", d, 32'h06);
        chk("R7 no data", got_cnt - g0, 0);
        chk("R7 stop", stops - p0, 1);

        // R6 data NACK
        nack_data = 1;
        reg_wr(3'd0, {SLV, 1'b0}); reg_wr(3'd1, 32'h7);
        wait_done("R6n");
        reg_rd(3'd1, d); chk("R6 data nack", d, 32'h0A);
        nack_data = 0;

        // R4 hold, R9 data-only, R5 repeated START read
        s0 = starts; p0 = stops;
        reg_wr(3'd2, 32'h11); reg_wr(3'd1, 32'h3);
        wait_done("R4h");
        reg_rd(3'd1, d); chk("R4 held status", d, 32'h10);
        chk("R4 scl held low", scl_oe, 1);
        reg_wr(3'd2, 32'h22); reg_wr(3'd1, 32'h1);
        wait_done("R9");
        chk("R9 data only", got_byte, 8'h22);
        chk("R9 no new start", starts - s0, 1);
        rd_byte = 8'h5C;
        reg_wr(3'd0, {SLV, 1'b1}); reg_wr(3'd1, 32'h7);
        wait_done("R5");
        chk("R5 repeated start", starts - s0, 2);
        chk("R5 no stop between", stops - p0, 1);
        reg_rd(3'd2, d); chk("R8 read byte", d, 8'h5C);
        chk("R8 nack on ACK=0", mack, 0);

        // R8 acknowledged read, then NACKed continuation
        rd_byte = 8'hC3;
        reg_wr(3'd1, 32'hB);
        wait_done("R8a");
        reg_rd(3'd2, d); chk("R8 read acked", d, 8'hC3);
        chk("R8 master ack", mack, 1);
        reg_wr(3'd1, 32'h5);
        wait_done("R8b");
        reg_rd(3'd2, d); chk("R8 read cont", d, 8'hC3);
        chk("R8 master nack", mack, 0);
        reg_rd(3'd1, d); chk("R8 status", d, 0);

        // R10 command while busy is ignored
        s0 = starts;
        reg_wr(3'd0, {SLV, 1'b0}); reg_wr(3'd1, 32'h7);
        repeat (8) @(negedge clk);
        reg_wr(3'd1, 32'h7);
        wait_done("R10");
        repeat (300) @(negedge clk);
        chk("R10 single start", starts - s0, 1);
        chk("R10 no extra irq", irq, 0);

        // R11 masked flag and write-one-to-clear
        reg_wr(3'd4, 32'd0);
        reg_wr(3'd1, 32'h7);
        repeat (400) @(negedge clk);
        reg_rd(3'd5, d); chk("R11 flag set", d, 1);
        chk("R11 masked pin", irq, 0);
        reg_wr(3'd4, 32'd1);
        @(negedge clk); chk("R11 pin unmasked", irq, 1);
        reg_wr(3'd5, 32'd0);
        reg_rd(3'd5, d); chk("R11 write 0 keeps", d, 1);
        reg_wr(3'd5, 32'd1);
        reg_rd(3'd5, d); chk("R11 w1c", d, 0);

        // R12 SCL high time, plain and after stretch
        reg_wr(3'd3, 32'd6);
        s0 = starts;
        reg_wr(3'd1, 32'h7);
        while (starts == s0) @(negedge clk);
        while (scl_line) @(negedge clk);
        while (!scl_line) @(negedge clk);
        n = 0;
        while (scl_line) begin n++; @(negedge clk); end
        chk("R12 high phase", n, 6);
        #1 stretch = 1;
        repeat (20) @(negedge clk);
        stretch = 0;
        #1 n = 0;
        while (scl_line) begin n++; @(negedge clk); end
        chk("R12 high after stretch", n, 6);
        wait_done("R12");
        reg_rd(3'd1, d); chk("R12 status", d, 0);
        reg_wr(3'd3, 32'd3);

        // Random transfers, R13 through start/stop counts
        for (int i = 0; i < 40; i++) begin
            logic m = 1'($urandom % 2);
            logic r = 1'($urandom % 2);
            logic k = 1'($urandom % 2);
            logic [7:0] dt = 8'($urandom);
            logic [6:0] a7 = m ? SLV : (SLV ^ 7'($urandom_range(1, 127)));
            rd_byte = 8'($urandom);
            nack_data = k;
            s0 = starts; p0 = stops; g0 = got_cnt;
            reg_wr(3'd0, {a7, r}); reg_wr(3'd2, {24'd0, dt}); reg_wr(3'd1, 32'h7);
            wait_done("rand");
            reg_rd(3'd1, d); chk("R6/R7 rand status", d, exp_status(m, r, k, 1'b0));
            chk("R13 rand start/stop", {starts - s0, stops - p0}, {32'd1, 32'd1});
            if (m && r) begin
                reg_rd(3'd2, d); chk("R8 rand read", d, {24'd0, rd_byte});
            end
            if (m && !r) chk("R6 rand write", got_byte, dt);
            else         chk("R7 rand no write", got_cnt - g0, 0);
        end

        summary();
        $finish;
    end
endmodule